// File: doc/BRIEF.md
# Serial SAR Converter Front-End

This block is the digital half of a 10-bit successive-approximation converter that a host reaches over a four-wire serial port. The host lowers chip select and clocks in a start bit, a mode flag and a three-bit channel code. The block routes the addressed input or input pair to the analog side and opens the sample window. It then resolves one result bit on each falling serial-clock edge. It does this by trying a DAC code, reading a single comparator decision and keeping or clearing the trial bit.

All logic runs on a fast system clock. Chip select, serial clock and data-in are synchronised to it, and serial edges are found from the synchronised copies. The result leaves on the serial output as a low null bit and then the word MSB first. If the host keeps clocking, the word follows again LSB first, and after that only zeros are sent. The same word is also held on a parallel port and marked by a one-cycle valid pulse.

Top module: `sarfe_top`

## Requirements
- R1: With chip select low, the first rising serial edge that samples data-in high is taken as the start bit. Zeros clocked in before it change no output.
- R2: The four rising edges after the start bit capture, in this order, the mode flag (1 = single-ended), then code bits 2, 1 and 0. In single-ended mode `pos_ch` equals the code, `neg_ch` is 0 and `diff_mode` is 0.
- R3: In differential mode (flag 0), `diff_mode` is 1 and the pair is {code[2:1],0} and {code[2:1],1}. Code bit 0 = 0 makes the even input positive, and code bit 0 = 1 makes the odd input positive.
- R4: `sample_en` rises on the fourth rising edge after the start bit and falls on the falling edge of the fifth clock after it. Data-in on that fifth clock is ignored.
- R5: On the falling edge that ends sampling, `dout_oe` rises and `dout` is 0 (the null bit). The next ten falling edges put out result bits 9 down to 0. The result is the straight-binary code, where bit k is 1 when the comparator reports the input at or above the trial code.
- R6: One system cycle after bit 0 is decided, `result_valid` pulses high for exactly one cycle, and `result` then holds the converted code until the next conversion.
- R7: Falling edges after bit 0, with chip select still low, output bits 1 up to 9 and then 0 on every further edge.
- R8: `dout_oe` is 0 while chip select is high and before the null bit. Raising chip select at any point ends the transfer, clears `sample_en` and `dout_oe`, and produces no `result_valid`.
- R9: If chip select is low when reset is released, no transfer is accepted until chip select has gone high and then low again.
- R10: `pwr_down` rises with the decision of bit 0, stays high through the LSB-first replay and the zero fill, and drops once chip select goes high.
- R11: When sampling ends, `dac_code` presents the first trial code, which has only the MSB set (0x200).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| din | input | 1 | Serial command input |
| cmp_in | input | 1 | Comparator decision: 1 when input is at or above `dac_code` |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Output enable for `dout` (0 = high impedance) |
| sample_en | output | 1 | Hold capacitor tracking window |
| diff_mode | output | 1 | 1 when the routed input is a pseudo-differential pair |
| pos_ch | output | 3 | Positive input selection |
| neg_ch | output | 3 | Negative input selection (0 in single-ended mode) |
| dac_code | output | 10 | Trial code for the DAC |
| result | output | 10 | Last completed conversion |
| result_valid | output | 1 | One-cycle pulse when `result` updates |
| pwr_down | output | 1 | Comparator and bias power-down request |

## Verification
The bench models the analog side: eight channel levels and a comparator that reads `dac_code` and the routing outputs. If the block routes the wrong input, every other channel holds a filler level, so the word comes out wrong. It drives patterns with a variable number of leading zeros. A miscounted start bit would shift every later field by one bit. It also drives both pair orders in differential mode and a negative difference that must clamp to 0. It checks the edge on which the sample window closes, where an off-by-one design would close it a clock early or late. It checks the replay order and the zero fill, where a wrong design would repeat bit 0 or wrap. Finally it covers aborts during sampling and during conversion, and a reset released with chip select already low. A careless design would take a transfer there, raise a valid pulse or leave the output enabled.

// File: rtl/sarfe_pkg.sv
`timescale 1ns/1ps
package sarfe_pkg;

    localparam int RES_W = 10;
    localparam int CH_W  = 3;

    typedef enum logic [3:0] {
        ST_LOCK,
        ST_IDLE,
        ST_HUNT,
        ST_CMD,
        ST_SAMP_A,
        ST_SAMP_B,
        ST_CONV,
        ST_REPLAY,
        ST_ZERO
    } fe_state_e;

    typedef struct packed {
        logic            diff;
        logic [CH_W-1:0] pos;
        logic [CH_W-1:0] neg;
    } ch_route_t;

    // Map the mode flag and channel code onto mux selections.
    function automatic ch_route_t route_decode(input logic single, input logic [CH_W-1:0] code);
        ch_route_t r;
        r.diff = ~single;
        r.pos  = code;
        if (single) begin
            r.neg = '0;
        end else begin
            r.neg = {code[CH_W-1:1], ~code[0]};
        end
        return r;
    endfunction

endpackage

// File: rtl/sarfe_sync.sv
`timescale 1ns/1ps
module sarfe_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] tap [STAGES+1];

    assign tap[0] = d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r;
        always_ff @(posedge clk) begin
            if (rst) r <= '0;
            else     r <= tap[g];
        end
        assign tap[g+1] = r;
    end

    assign q = tap[STAGES];
endmodule

// File: rtl/sarfe_sar.sv
`timescale 1ns/1ps
module sarfe_sar #(
    parameter int RES_W = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             load,
    input  logic             step,
    input  logic [CNT_W-1:0] idx,
    input  logic             cmp,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             result_valid
);
    localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] trial_q;
    logic [RES_W-1:0] trial_nx;
    logic [RES_W-1:0] res_q;
    logic             vld_q;

    // Fix the bit under test from the comparator, arm the next lower bit.
    always_comb begin
        trial_nx = trial_q;
        for (int b = 0; b < RES_W; b++) begin
            if (b == int'(idx))          trial_nx[b] = cmp;
            else if (b + 1 == int'(idx)) trial_nx[b] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= '0;
            res_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (abort) begin
                trial_q <= '0;
            end else if (load) begin
                trial_q <= FIRST_TRIAL;
            end else if (step) begin
                trial_q <= trial_nx;
                if (idx == '0) begin
                    res_q <= trial_nx;
                    vld_q <= 1'b1;
                end
            end
        end
    end

    assign dac_code     = trial_q;
    assign result       = res_q;
    assign result_valid = vld_q;
endmodule

// File: rtl/sarfe_seq.sv
`timescale 1ns/1ps
module sarfe_seq
    import sarfe_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n_s,
    input  logic             sclk_s,
    input  logic             din_s,
    input  logic             cmp_in,
    input  logic [RES_W-1:0] result,
    output logic             sar_abort,
    output logic             sar_load,
    output logic             sar_step,
    output logic [CNT_W-1:0] sar_idx,
    output logic             dout,
    output logic             dout_oe,
    output logic             sample_en,
    output logic             pwr_down,
    output ch_route_t        route
);
    localparam logic [CNT_W-1:0] CMD_LAST = CNT_W'(CH_W);
    localparam logic [CNT_W-1:0] BIT_TOP  = CNT_W'(RES_W - 1);

    fe_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CH_W-1:0]  cmd_q;
    logic             sclk_d;
    logic             dout_q;
    logic             oe_q;
    logic             samp_q;
    ch_route_t        route_q;
    logic             sclk_rise;
    logic             sclk_fall;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOCK;
            cnt_q   <= '0;
            cmd_q   <= '0;
            sclk_d  <= 1'b0;
            dout_q  <= 1'b0;
            oe_q    <= 1'b0;
            samp_q  <= 1'b0;
            route_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (cs_n_s) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
                dout_q  <= 1'b0;
                oe_q    <= 1'b0;
                samp_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_LOCK: state_q <= ST_LOCK;
                    ST_IDLE: state_q <= ST_HUNT;
                    ST_HUNT: begin
                        if (sclk_rise && din_s) begin
                            state_q <= ST_CMD;
                            cnt_q   <= '0;
                        end
                    end
                    ST_CMD: begin
                        if (sclk_rise) begin
                            cmd_q <= {cmd_q[CH_W-2:0], din_s};
                            if (cnt_q == CMD_LAST) begin
                                route_q <= route_decode(cmd_q[CH_W-1], {cmd_q[CH_W-2:0], din_s});
                                samp_q  <= 1'b1;
                                state_q <= ST_SAMP_A;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                    end
                    ST_SAMP_A: begin
                        if (sclk_rise) state_q <= ST_SAMP_B;
                    end
                    ST_SAMP_B: begin
                        if (sclk_fall) begin
                            samp_q  <= 1'b0;
                            oe_q    <= 1'b1;
                            dout_q  <= 1'b0;
                            cnt_q   <= BIT_TOP;
                            state_q <= ST_CONV;
                        end
                    end
                    ST_CONV: begin
                        if (sclk_fall) begin
                            dout_q <= cmp_in;
                            if (cnt_q == '0) begin
                                cnt_q   <= CNT_W'(1);
                                state_q <= ST_REPLAY;
                            end else begin
                                cnt_q <= cnt_q - 1'b1;
                            end
                        end
                    end
                    ST_REPLAY: begin
                        if (sclk_fall) begin
                            dout_q <= result[cnt_q];
                            if (cnt_q == BIT_TOP) state_q <= ST_ZERO;
                            else                  cnt_q   <= cnt_q + 1'b1;
                        end
                    end
                    ST_ZERO: begin
                        if (sclk_fall) dout_q <= 1'b0;
                    end
                    default: state_q <= ST_LOCK;
                endcase
            end
        end
    end

    assign sar_abort = cs_n_s;
    assign sar_load  = ~cs_n_s && (state_q == ST_SAMP_B) && sclk_fall;
    assign sar_step  = ~cs_n_s && (state_q == ST_CONV) && sclk_fall;
    assign sar_idx   = cnt_q;
    assign dout      = dout_q;
    assign dout_oe   = oe_q;
    assign sample_en = samp_q;
    assign pwr_down  = (state_q == ST_REPLAY) || (state_q == ST_ZERO);
    assign route     = route_q;
endmodule

// File: rtl/sarfe_top.sv
`timescale 1ns/1ps
module sarfe_top
    import sarfe_pkg::*;
#(
    parameter int RES_W       = sarfe_pkg::RES_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             cmp_in,
    output logic             dout,
    output logic             dout_oe,
    output logic             sample_en,
    output logic             diff_mode,
    output logic [CH_W-1:0]  pos_ch,
    output logic [CH_W-1:0]  neg_ch,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] result,
    output logic             result_valid,
    output logic             pwr_down
);
    localparam int CNT_W = $clog2(RES_W + CH_W + 1);

    logic [2:0]       raw_in;
    logic [2:0]       sync_q;
    logic             cs_n_s;
    logic             sclk_s;
    logic             din_s;
    logic             sar_abort;
    logic             sar_load;
    logic             sar_step;
    logic [CNT_W-1:0] sar_idx;
    ch_route_t        route;

    assign raw_in = {cs_n, sclk, din};

    sarfe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    assign cs_n_s = sync_q[2];
    assign sclk_s = sync_q[1];
    assign din_s  = sync_q[0];

    sarfe_seq #(.RES_W(RES_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cs_n_s    (cs_n_s),
        .sclk_s    (sclk_s),
        .din_s     (din_s),
        .cmp_in    (cmp_in),
        .result    (result),
        .sar_abort (sar_abort),
        .sar_load  (sar_load),
        .sar_step  (sar_step),
        .sar_idx   (sar_idx),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .sample_en (sample_en),
        .pwr_down  (pwr_down),
        .route     (route)
    );

    sarfe_sar #(.RES_W(RES_W), .CNT_W(CNT_W)) u_sar (
        .clk          (clk),
        .rst          (rst),
        .abort        (sar_abort),
        .load         (sar_load),
        .step         (sar_step),
        .idx          (sar_idx),
        .cmp          (cmp_in),
        .dac_code     (dac_code),
        .result       (result),
        .result_valid (result_valid)
    );

    assign diff_mode = route.diff;
    assign pos_ch    = route.pos;
    assign neg_ch    = route.neg;
endmodule

// File: rtl/sarfe_chk.sv
`timescale 1ns/1ps
module sarfe_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_n_s,
    input logic             dout,
    input logic             dout_oe,
    input logic             sample_en,
    input logic             pwr_down,
    input logic             result_valid,
    input logic [RES_W-1:0] dac_code
);
    localparam logic [RES_W-1:0] FIRST_TRIAL = {1'b1, {(RES_W-1){1'b0}}};

    p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !dout_oe);

    p_null_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> !dout);

    p_first_trial_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(dout_oe) |-> dac_code == FIRST_TRIAL);

    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    p_window_closed_r4: assert property (@(posedge clk) disable iff (rst)
        sample_en |-> (!dout_oe && !pwr_down));

    p_pd_with_valid_r10: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> pwr_down);

    p_pd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (pwr_down && !cs_n_s) |=> pwr_down);
endmodule

bind sarfe_top sarfe_chk #(.RES_W(RES_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cs_n_s       (cs_n_s),
    .dout         (dout),
    .dout_oe      (dout_oe),
    .sample_en    (sample_en),
    .pwr_down     (pwr_down),
    .result_valid (result_valid),
    .dac_code     (dac_code)
);

// File: tb/sarfe_top_tb.sv
`timescale 1ns/1ps
module sarfe_top_tb;

    typedef struct packed {
        logic       sgl;
        logic [2:0] code;
        logic [3:0] lead;
        logic [9:0] vp;
        logic [9:0] vn;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 3'd0, 4'd0, 10'h000, 10'h000},
        '{1'b1, 3'd7, 4'd2, 10'h3FF, 10'h000},
        '{1'b1, 3'd3, 4'd5, 10'h2AA, 10'h000},
        '{1'b1, 3'd4, 4'd0, 10'h155, 10'h000},
        '{1'b0, 3'd2, 4'd1, 10'h1F4, 10'h064},
        '{1'b0, 3'd5, 4'd0, 10'h300, 10'h010},
        '{1'b0, 3'd6, 4'd3, 10'h050, 10'h0A0},
        '{1'b0, 3'd1, 4'd7, 10'h3FF, 10'h000}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       din = 1'b0;
    logic       cmp_in;
    logic       dout, dout_oe, sample_en, diff_mode, result_valid, pwr_down;
    logic [2:0] pos_ch, neg_ch;
    logic [9:0] dac_code, result;

    int chan_v [8];
    int checks = 0;
    int errors = 0;
    int vcnt = 0;
    int pv, nv;

    always #2.5 clk = ~clk;

    sarfe_top u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_in(cmp_in),
        .dout(dout), .dout_oe(dout_oe), .sample_en(sample_en), .diff_mode(diff_mode),
        .pos_ch(pos_ch), .neg_ch(neg_ch), .dac_code(dac_code), .result(result),
        .result_valid(result_valid), .pwr_down(pwr_down)
    );

    // Analog model: selected level (minus negative input) against DAC trial.
    always_comb begin
        pv = chan_v[pos_ch];
        nv = diff_mode ? chan_v[neg_ch] : 0;
        cmp_in = ((pv - nv) >= int'(dac_code));
    end

    always @(posedge clk) begin
        if (rst) vcnt <= 0;
        else if (result_valid) vcnt <= vcnt + 1;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One serial clock (mode 0): data set while low, outputs read late in the next low phase.
    task automatic tick(input logic d, output logic o, output logic oe, output logic se);
        @(negedge clk) din = d;
        repeat (8) @(negedge clk);
        sclk = 1'b1;
        repeat (8) @(negedge clk);
        sclk = 1'b0;
        repeat (8) @(negedge clk);
        o  = dout;
        oe = dout_oe;
        se = sample_en;
    endtask

    function automatic logic [9:0] expect_code(input vec_t v);
        if (v.sgl) return v.vp;
        if (v.vp > v.vn) return v.vp - v.vn;
        return 10'h000;
    endfunction

    task automatic run_xfer(input vec_t v);
        logic o, oe, se;
        logic [9:0] ew, got;
        logic early, lost, bad;
        int v0;
        ew = expect_code(v);
        for (int c = 0; c < 8; c++) chan_v[c] = 'h123;
        chan_v[v.code] = int'(v.vp);
        if (!v.sgl) chan_v[v.code ^ 3'd1] = int'(v.vn);
        v0 = vcnt;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        early = 1'b0;
        for (int i = 0; i < int'(v.lead); i++) begin
            tick(1'b0, o, oe, se);
            early |= oe | se;
        end
        tick(1'b1, o, oe, se);          early |= oe | se;
        tick(v.sgl, o, oe, se);         early |= oe | se;
        tick(v.code[2], o, oe, se);     early |= oe | se;
        tick(v.code[1], o, oe, se);
        chk(!(early | oe), "R1 leading/start quiet", {31'd0, early | oe}, 0);
        chk(se == 1'b0, "R4 window closed before 4th edge", se, 0);
        tick(v.code[0], o, oe, se);
        chk(se == 1'b1, "R4 window open after 4th edge", se, 1);
        if (v.sgl)
            chk({diff_mode, pos_ch, neg_ch} == {1'b0, v.code, 3'd0}, "R2 single route",
                {diff_mode, pos_ch, neg_ch}, {1'b0, v.code, 3'd0});
        else
            chk({diff_mode, pos_ch, neg_ch} == {1'b1, v.code, v.code ^ 3'd1}, "R3 pair route",
                {diff_mode, pos_ch, neg_ch}, {1'b1, v.code, v.code ^ 3'd1});
        chk(oe == 1'b0, "R8 hi-z before null", oe, 0);
        tick(1'b1, o, oe, se);
        chk(oe == 1'b1 && o == 1'b0, "R5 null bit", {oe, o}, 2'b10);
        chk(se == 1'b0, "R4 window closed on 5th fall", se, 0);
        chk(dac_code == 10'h200, "R11 first trial", dac_code, 10'h200);
        lost = 1'b0;
        got = '0;
        for (int j = 9; j >= 0; j--) begin
            tick(1'b1, o, oe, se);
            got[j] = o;
            lost |= ~oe;
            if (j == 1) chk(pwr_down == 1'b0, "R10 no power-down mid conversion", pwr_down, 0);
        end
        chk(got == ew && !lost, "R5 MSB-first word", got, ew);
        chk(result == ew, "R6 parallel result", result, ew);
        chk(vcnt == v0 + 1, "R6 one valid pulse", vcnt - v0, 1);
        chk(pwr_down == 1'b1, "R10 power-down after B0", pwr_down, 1);
        bad = 1'b0;
        got = '0;
        for (int k = 1; k <= 9; k++) begin
            tick(1'b0, o, oe, se);
            got[k] = o;
        end
        got[0] = ew[0];
        chk(got == ew, "R7 LSB-first replay", got, ew);
        for (int z = 0; z < 3; z++) begin
            tick(1'b1, o, oe, se);
            bad |= o;
        end
        chk(!bad, "R7 zero fill", bad, 0);
        chk(pwr_down == 1'b1, "R10 power-down through fill", pwr_down, 1);
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(dout_oe == 1'b0, "R8 hi-z after cs high", dout_oe, 0);
        chk(pwr_down == 1'b0, "R10 release on cs high", pwr_down, 0);
        repeat (8) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic o, oe, se;
        logic any_act;
        int v0;
        for (int c = 0; c < 8; c++) chan_v[c] = 0;
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        chk({dout_oe, sample_en, pwr_down, result_valid} == 4'b0, "R8 reset outputs idle",
            {dout_oe, sample_en, pwr_down, result_valid}, 0);
        chk(result == 10'h000, "R6 reset result", result, 0);

        // Main table walk.
        for (int i = 0; i < NVEC; i++) run_xfer(VECS[i]);

        // R9: reset released with chip select already low.
        @(negedge clk) begin cs_n = 1'b0; rst = 1'b1; end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (8) @(negedge clk);
        v0 = vcnt;
        any_act = 1'b0;
        tick(1'b1, o, oe, se); any_act |= oe | se;
        for (int i = 0; i < 16; i++) begin
            tick(1'b1, o, oe, se);
            any_act |= oe | se | pwr_down;
        end
        chk(!any_act && vcnt == v0, "R9 locked until cs toggles", {31'd0, any_act}, 0);
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
        run_xfer(VECS[2]);

        // R8: abort inside the sample window.
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        tick(1'b1, o, oe, se);
        tick(1'b1, o, oe, se);
        tick(1'b0, o, oe, se);
        tick(1'b1, o, oe, se);
        tick(1'b1, o, oe, se);
        chk(se == 1'b1, "R4 window open before abort", se, 1);
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(sample_en == 1'b0, "R8 abort closes window", sample_en, 0);

        // R8: abort in the middle of conversion.
        v0 = vcnt;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 10; i++) tick(i == 0 ? 1'b1 : 1'b0, o, oe, se);
        chk(oe == 1'b1, "R5 driving mid conversion", oe, 1);
        @(negedge clk) cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(dout_oe == 1'b0 && pwr_down == 1'b0, "R8 abort releases output",
            {dout_oe, pwr_down}, 0);
        repeat (40) @(negedge clk);
        chk(vcnt == v0, "R8 abort gives no valid", vcnt - v0, 0);
        run_xfer(VECS[5]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule